// File: doc/BRIEF.md
# Serial Frame CRC-8 Engine

This block computes an 8-bit cyclic check over the bytes of a serial message on a single-wire vehicle network link. A link-layer sequencer feeds it one bit at a time, most significant bit of each byte first. It pulses a clear at the start of every frame and an end-of-data strobe once the last bit has been shifted. Bit timing, symbol decoding and arbitration stay with that sequencer.

To transmit, the sequencer shifts in the data bits and then sends the check byte output, most significant bit first. That output is always the inverse of the running remainder. To receive, the sequencer shifts in every data bit and then the received check byte through the same register. At end of data the block raises an error flag unless the register holds the fixed residue 0xC4. It also raises a separate length flag when the frame was too short to contain one data byte plus the check byte.

Top module: `crc8_frame_engine`

## Requirements
- R1: Each clock cycle with `bitValid` high shifts `bitIn` into the remainder using the divisor x^8+x^4+x^3+x^2+1 (0x1D), MSB-first. The feedback is remainder bit 7 XOR `bitIn`. The new remainder is the old one shifted left by one, XORed with 0x1D when the feedback is 1.
- R2: After reset, and in the cycle after a `sofClr` pulse, the remainder is 0xFF, so `crcByte` reads 0x00.
- R3: When `sofClr` and `bitValid` are high in the same cycle, the preset wins and the bit is discarded.
- R4: In a cycle with neither `sofClr` nor `bitValid`, the remainder and `crcByte` keep their values, whatever `bitIn` does.
- R5: `crcByte` is the bitwise inverse of the remainder. Sending it MSB-first after the data and then pulsing `eodStrobe` leaves `crcError` low in the next cycle.
- R6: At `eodStrobe`, a remainder other than 0xC4 sets `crcError` in the next cycle. This includes a frame whose check byte has a single bit flipped.
- R7: `crcError` and `lengthError` change only on an `eodStrobe` (they are loaded then) or on a `sofClr` (they are cleared then). Further bit strobes after end of data leave them unchanged.
- R8: At `eodStrobe`, `lengthError` is set when fewer than 16 bits were shifted since the last `sofClr`, and is cleared when 16 or more were shifted.
- R9: After reset, both `crcError` and `lengthError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sofClr | input | 1 | Start of frame: presets remainder, clears flags and bit count |
| bitValid | input | 1 | Shift `bitIn` this cycle |
| bitIn | input | 1 | Serial data bit, MSB of each byte first |
| eodStrobe | input | 1 | End of data: evaluate both flags |
| crcByte | output | 8 | Inverted remainder (check byte to transmit) |
| crcError | output | 1 | Remainder differed from 0xC4 at the last end of data |
| lengthError | output | 1 | Fewer than 16 bits at the last end of data |

## Verification
Every result is registered. The remainder, and with it `crcByte`, reflects a strobe one clock after the edge that samples the strobe. Both flags reflect an `eodStrobe` or `sofClr` one clock later in the same way. The bench changes its inputs just after a rising edge and lets exactly one edge pass before it samples. It reads the outputs in that quiet window, at the first point where the registered value is due. For the hold cases it lets several idle or extra-bit cycles pass and confirms that nothing moved.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  typedef struct packed {
    logic load;   // preset remainder, clear flags and count
    logic shift;  // absorb one serial bit
    logic eval;   // evaluate flags at end of data
  } crcStrobes_t;
endpackage

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
  import crc8_pkg::*;
#(
  parameter int MinFrameBits = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sofClr,
  input  logic        bitValid,
  input  logic        eodStrobe,
  output crcStrobes_t strb,
  output logic        lengthError
);
  localparam int CntW = $clog2(MinFrameBits + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(MinFrameBits);

  logic [CntW-1:0] bitCount;

  always_comb begin
    strb.load  = sofClr;
    strb.shift = bitValid && !sofClr;
    strb.eval  = eodStrobe && !sofClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount    <= '0;
      lengthError <= 1'b0;
    end else begin
      if (strb.load) begin
        bitCount    <= '0;
        lengthError <= 1'b0;
      end else begin
        if (strb.shift && bitCount != CntMax) bitCount <= bitCount + 1'b1;
        if (strb.eval) lengthError <= (bitCount < CntMax);
      end
    end
  end

  // R8: the length flag only rises as a result of an end-of-data strobe
  p_len_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lengthError) |-> $past(eodStrobe));

  // R7: a start of frame always leaves the length flag low
  p_len_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    sofClr |=> !lengthError);
endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int          CrcW    = 8,
  parameter logic [CrcW-1:0] Poly    = 8'h1D,
  parameter logic [CrcW-1:0] Init    = 8'hFF,
  parameter logic [CrcW-1:0] Residue = 8'hC4
) (
  input  logic            clk,
  input  logic            rstN,
  input  crcStrobes_t     strb,
  input  logic            bitIn,
  output logic [CrcW-1:0] crcByte,
  output logic            crcError
);
  logic [CrcW-1:0] crcRem;
  logic [CrcW-1:0] nextRem;
  logic            feedback;

  always_comb begin
    feedback = crcRem[CrcW-1] ^ bitIn;
    nextRem  = {crcRem[CrcW-2:0], 1'b0} ^ (feedback ? Poly : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcRem   <= Init;
      crcError <= 1'b0;
    end else if (strb.load) begin
      crcRem   <= Init;
      crcError <= 1'b0;
    end else begin
      if (strb.shift) crcRem <= nextRem;
      if (strb.eval)  crcError <= (crcRem != Residue);
    end
  end

  assign crcByte = ~crcRem;

  // R2: preset value follows a load strobe
  p_preset_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> crcByte == ~Init);

  // R4: without load or shift the remainder holds
  p_rem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.shift |=> $stable(crcByte));

  // R7: the check flag holds outside end of data and start of frame
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.eval |=> $stable(crcError));

  // R6: the check flag rises only after an evaluation
  p_err_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcError) |-> $past(strb.eval));
endmodule

// File: rtl/crc8_frame_engine.sv
module crc8_frame_engine
  import crc8_pkg::*;
#(
  parameter int          CrcW         = 8,
  parameter logic [CrcW-1:0] Poly         = 8'h1D,
  parameter logic [CrcW-1:0] Init         = 8'hFF,
  parameter logic [CrcW-1:0] Residue      = 8'hC4,
  parameter int          MinFrameBits = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sofClr,
  input  logic            bitValid,
  input  logic            bitIn,
  input  logic            eodStrobe,
  output logic [CrcW-1:0] crcByte,
  output logic            crcError,
  output logic            lengthError
);
  crcStrobes_t strb;

  crc8_ctrl #(.MinFrameBits(MinFrameBits)) u_ctrl (
    .clk(clk), .rstN(rstN), .sofClr(sofClr), .bitValid(bitValid),
    .eodStrobe(eodStrobe), .strb(strb), .lengthError(lengthError)
  );

  crc8_datapath #(.CrcW(CrcW), .Poly(Poly), .Init(Init), .Residue(Residue)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn),
    .crcByte(crcByte), .crcError(crcError)
  );
endmodule

// File: tb/crc8_frame_engine_bench.sv
module crc8_frame_engine_bench;
  localparam time ClkPeriod = 10ns;
  // entry: [39:32] byte count (1..4), [31:0] bytes, first byte in [31:24]
  localparam logic [39:0] Vecs [0:5] = '{
    {8'd1, 32'h00000000}, {8'd1, 32'hFF000000}, {8'd2, 32'h55AA0000},
    {8'd3, 32'h12345600}, {8'd4, 32'hDEADBEEF}, {8'd4, 32'h01020304}
  };

  logic clk = 0, rstN = 0, sofClr = 0, bitValid = 0, bitIn = 0, eodStrobe = 0;
  logic [7:0] crcByte;
  logic crcError, lengthError;
  int total = 0, bad = 0;
  logic [7:0] held;

  crc8_frame_engine u_crc8_frame_engine (
    .clk(clk), .rstN(rstN), .sofClr(sofClr), .bitValid(bitValid), .bitIn(bitIn),
    .eodStrobe(eodStrobe), .crcByte(crcByte), .crcError(crcError),
    .lengthError(lengthError)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [7:0] modelByte(logic [7:0] r, logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ b[i]) r = (r << 1) ^ 8'h1D;
      else             r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic v, logic b, logic e);
    sofClr = s; bitValid = v; bitIn = b; eodStrobe = e;
    @(posedge clk); #1;
    sofClr = 0; bitValid = 0; bitIn = 0; eodStrobe = 0;
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) cyc(0, 1, b[i], 0);
  endtask

  initial begin
    #(ClkPeriod * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset crcByte", crcByte, 8'h00);
    chk("R9 reset crcError", {7'd0, crcError}, 8'd0);
    chk("R9 reset lengthError", {7'd0, lengthError}, 8'd0);
    rstN = 1;
    @(posedge clk); #1;

    for (int k = 0; k < 6; k++) begin
      int n = int'(Vecs[k][39:32]);
      logic [7:0] r = 8'hFF;
      logic [7:0] ck;
      for (int pass = 0; pass < 2; pass++) begin
        r = 8'hFF;
        cyc(1, 0, 0, 0);
        for (int j = 0; j < n; j++) begin
          logic [7:0] d = Vecs[k][31 - 8*j -: 8];
          sendBits(d, 8);
          r = modelByte(r, d);
        end
        ck = ~r;
        if (pass == 0) chk($sformatf("R1 crcByte vec%0d", k), crcByte, ck);
        sendBits(pass == 0 ? ck : ck ^ 8'h01, 8);
        cyc(0, 0, 0, 1);
        if (pass == 0) chk($sformatf("R5 good frame vec%0d", k), {7'd0, crcError}, 8'd0);
        else           chk($sformatf("R6 corrupt frame vec%0d", k), {7'd0, crcError}, 8'd1);
        chk($sformatf("R8 long enough vec%0d", k), {7'd0, lengthError}, 8'd0);
      end
    end

    // R7: extra bits after a failed end of data leave the flag set
    repeat (5) cyc(0, 1, 1, 0);
    chk("R7 flag held after bits", {7'd0, crcError}, 8'd1);
    cyc(1, 0, 0, 0);
    chk("R7 sof clears crcError", {7'd0, crcError}, 8'd0);

    // R3: preset wins over a same-cycle bit
    cyc(0, 1, 1, 0);
    cyc(1, 1, 1, 0);
    chk("R3 sof priority", crcByte, 8'h00);

    // R4: idle cycles with bitIn toggling
    sendBits(8'hA7, 8);
    held = ~modelByte(8'hFF, 8'hA7);
    chk("R1 single byte", crcByte, held);
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], 0);
    chk("R4 hold while idle", crcByte, held);

    // R8: 15 bits is short, exactly 16 is enough
    sendBits(held, 7);
    cyc(0, 0, 0, 1);
    chk("R8 15 bits short", {7'd0, lengthError}, 8'd1);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R7 length flag held", {7'd0, lengthError}, 8'd1);
    cyc(1, 0, 0, 0);
    chk("R7 sof clears lengthError", {7'd0, lengthError}, 8'd0);
    sendBits(8'hA7, 8);
    sendBits(held, 8);
    cyc(0, 0, 0, 1);
    chk("R8 16 bits boundary", {7'd0, lengthError}, 8'd0);
    chk("R5 boundary frame good", {7'd0, crcError}, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule